// File: doc/BRIEF.md
# Deglitched Fault Flag Controller

This block drives the fault indicator of a current-limited load switch and decides whether the switch may conduct. It takes five digital status inputs: enable, supply-good (the undervoltage lockout has released), current-limit active, overtemperature and cooled. All of them pass through a synchronizer before any decision is made. The fault indicator is an active-low open-drain pin. The block only produces the gate enable for its pull-down transistor, so a deasserted flag leaves the pin floating and the pin is never driven high.

The flag is filtered by a clock-cycle timer on both edges. A fault condition must stay present for a full deglitch interval before the flag pulls low. The condition must then stay absent for a full interval before the flag lets go. Any interruption restarts the timer from zero, so short events never add up. There are three exceptions. Overtemperature while in current limit pulls the flag low at once. Loss of enable releases the flag at once. Loss of supply-good releases the flag at once. Thermal shutdown latches the switch off until a separate cooled indication arrives.

Top module: `fault_flag_ctrl`

## Requirements
- R1: While reset is held, and after it is released with enable low, `flag_pull_o` is 0 (pin floating) and `switch_on_o` is 0.
- R2: Every status input passes through SYNC_STAGES flops (2 by default) before it has any effect. A change on an input is therefore first visible to the flag and switch logic after two rising edges.
- R3: `flag_pull_o` = 1 means "pull the fault pin low". A current-limit condition held continuously, with enable and supply-good high, sets `flag_pull_o` to 1 exactly DEGLITCH_CYC+2 rising edges after the input rises. It is still 0 after DEGLITCH_CYC+1 edges.
- R4: A current-limit pulse lasting fewer than DEGLITCH_CYC cycles never sets the flag. Consecutive such pulses separated by a single quiet cycle never set it either, because the timer clears whenever the condition drops.
- R5: Once the flag is set, it clears exactly DEGLITCH_CYC+2 rising edges after the fault condition ends. A return of the condition during that interval restarts the release count from zero.
- R6: If overtemperature becomes active while current limit is active, the flag sets 3 rising edges after the overtemperature input rises, with no deglitch wait. Its release is still deglitched, counted from when the shutdown latch clears.
- R7: Dropping enable clears an active flag and drops `switch_on_o` 2 rising edges later. Raising enable again with the overload still present re-arms the full deglitch wait.
- R8: While supply-good is low, `flag_pull_o` stays 0 and `switch_on_o` stays 0 whatever the other inputs do. Overtemperature seen in this state does not latch a shutdown.
- R9: Current limit and overtemperature together, while enabled and supplied, latch thermal shutdown. `switch_on_o` then falls 3 edges after the overtemperature input and stays 0 until the cooled input is seen. The latch clears, and `switch_on_o` returns, 3 edges after cooled rises.
- R10: `switch_on_o` is high exactly when the synchronized enable and supply-good are high and no thermal shutdown is latched. It is high 2 edges after enable and supply-good are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Switch enable request |
| supply_ok_i | input | 1 | Input supply above the lockout threshold |
| ilim_i | input | 1 | Current regulation loop is limiting |
| otemp_i | input | 1 | Junction overtemperature detected |
| cooled_i | input | 1 | Junction has cooled past the restart hysteresis |
| flag_pull_o | output | 1 | Enable for the fault pin pull-down; 0 leaves the pin high impedance |
| switch_on_o | output | 1 | Request to turn the power switch on |

## Verification
The bench builds the block with DEGLITCH_CYC = 16 and the default two-stage synchronizer. This brings every current-limit pulse length from one cycle to two cycles past the interval within a short sweep. For each length, the flag is compared on every cycle against an arithmetic window: it opens at DEGLITCH_CYC+2 edges and closes at pulse length plus DEGLITCH_CYC+2 edges. The short interval also makes room for the cases that depend on exact cycle counts: trains of sub-threshold pulses, a one-cycle return of the fault that restarts the release timer, the overtemperature bypass, disable in the middle of a fault, and supply loss.

// File: rtl/ffc_pkg.sv
package ffc_pkg;

    // Bundle of the status inputs carried through the synchronizer.
    typedef struct packed {
        logic en;
        logic sup_ok;
        logic ilim;
        logic otemp;
        logic cooled;
    } ffc_status_t;

    localparam int STATUS_W = $bits(ffc_status_t);

endpackage

// File: rtl/ffc_sync.sv
module ffc_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);

    logic [WIDTH-1:0] stg_d [STAGES];
    logic [WIDTH-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg_q[g] <= '0;
            end else begin
                stg_q[g] <= stg_d[g];
            end
        end
    end

    assign dout_o = stg_q[STAGES-1];

    // R2
    sync_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stg_q[0] == $past(din_i));

endmodule

// File: rtl/ffc_thermal.sv
module ffc_thermal (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic ilim_i,
    input  logic otemp_i,
    input  logic cooled_i,
    output logic shutdown_o
);

    typedef struct packed {
        logic sd;
    } therm_t;

    therm_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (active_i && ilim_i && otemp_i) begin
            nxt_d.sd = 1'b1;
        end else if (cooled_i) begin
            nxt_d.sd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign shutdown_o = cur_q.sd;

    // R9
    trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.sd) |-> $past(active_i && ilim_i && otemp_i));

    // R9
    hold_until_cool_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.sd && !cooled_i) |=> cur_q.sd);

endmodule

// File: rtl/ffc_deglitch.sv
module ffc_deglitch #(
    parameter int CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic cond_i,
    input  logic bypass_i,
    output logic flag_o
);

    localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYC - 1);

    typedef struct packed {
        logic             flag;
        logic [CNT_W-1:0] cnt;
    } dg_t;

    dg_t cur_q, nxt_d;
    logic at_last;

    assign at_last = (cur_q.cnt == LAST);

    always_comb begin
        nxt_d = cur_q;
        if (!active_i) begin
            nxt_d.flag = 1'b0;
            nxt_d.cnt  = '0;
        end else if (!cur_q.flag) begin
            if (bypass_i) begin
                nxt_d.flag = 1'b1;
                nxt_d.cnt  = '0;
            end else if (cond_i) begin
                if (at_last) begin
                    nxt_d.flag = 1'b1;
                    nxt_d.cnt  = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end else begin
                nxt_d.cnt = '0;
            end
        end else begin
            if (!cond_i) begin
                if (at_last) begin
                    nxt_d.flag = 1'b0;
                    nxt_d.cnt  = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end else begin
                nxt_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign flag_o = cur_q.flag;

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= LAST);

    // R4
    no_accumulate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !cur_q.flag && !cond_i) |=> cur_q.cnt == '0);

    // R5
    release_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && cur_q.flag && cond_i) |=> (cur_q.flag && cur_q.cnt == '0));

    // R6
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cur_q.flag) |-> $past(bypass_i || at_last));

    // R7
    inactive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (!cur_q.flag && cur_q.cnt == '0));

endmodule

// File: rtl/fault_flag_ctrl.sv
module fault_flag_ctrl #(
    parameter int DEGLITCH_CYC = 1_125_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic supply_ok_i,
    input  logic ilim_i,
    input  logic otemp_i,
    input  logic cooled_i,
    output logic flag_pull_o,
    output logic switch_on_o
);

    import ffc_pkg::*;

    ffc_status_t raw_s, syn_s;
    logic [STATUS_W-1:0] syn_bits;
    logic active_s;
    logic shutdown_s;
    logic fault_cond_s;
    logic hot_trip_s;
    logic flag_s;

    always_comb begin
        raw_s.en     = en_i;
        raw_s.sup_ok = supply_ok_i;
        raw_s.ilim   = ilim_i;
        raw_s.otemp  = otemp_i;
        raw_s.cooled = cooled_i;
    end

    ffc_sync #(
        .WIDTH  (STATUS_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (raw_s),
        .dout_o (syn_bits)
    );

    assign syn_s        = ffc_status_t'(syn_bits);
    assign active_s     = syn_s.en && syn_s.sup_ok;
    assign hot_trip_s   = syn_s.ilim && syn_s.otemp;
    assign fault_cond_s = syn_s.ilim || shutdown_s;

    ffc_thermal u_thermal (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active_s),
        .ilim_i     (syn_s.ilim),
        .otemp_i    (syn_s.otemp),
        .cooled_i   (syn_s.cooled),
        .shutdown_o (shutdown_s)
    );

    ffc_deglitch #(
        .CYC (DEGLITCH_CYC)
    ) u_deglitch (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active_s),
        .cond_i   (fault_cond_s),
        .bypass_i (hot_trip_s),
        .flag_o   (flag_s)
    );

    // Gating with the live enable lets the pin release in the same cycle the switch is commanded off.
    assign flag_pull_o = flag_s && active_s;
    assign switch_on_o = active_s && !shutdown_s;

    // R8
    uvlo_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !syn_s.sup_ok |-> (!flag_pull_o && !switch_on_o));

    // R9
    shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_s |-> !switch_on_o);

endmodule

// File: tb/tb_fault_flag_ctrl.sv
module tb_fault_flag_ctrl;

    localparam int N = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ok = 1'b0, ilim = 1'b0, ot = 1'b0, cool = 1'b0;
    logic flag, sw;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fault_flag_ctrl #(
        .DEGLITCH_CYC (N),
        .SYNC_STAGES  (2)
    ) dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .supply_ok_i (ok),
        .ilim_i      (ilim),
        .otemp_i     (ot),
        .cooled_i    (cool),
        .flag_pull_o (flag),
        .switch_on_o (sw)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at %0t: actual=%0b expected=%0b", req, what, $time, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        chk("R1", "flag in reset", flag, 1'b0);
        chk("R1", "switch in reset", sw, 1'b0);
        rst_n = 1'b1;
        idle(4);
        chk("R1", "flag after reset", flag, 1'b0);
        chk("R1", "switch after reset", sw, 1'b0);

        // R10 / R2: enable and supply reach switch after two edges
        en = 1'b1; ok = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R10", "switch on", sw, k >= 2);
        end

        // R3 R4 R5: sweep of current-limit pulse lengths
        for (int len = 1; len <= N + 2; len++) begin
            ilim = 1'b1;
            for (int k = 1; k <= len + N + 6; k++) begin
                @(negedge clk);
                if (k == len) ilim = 1'b0;
                chk(len >= N ? "R3" : "R4", "flag in pulse sweep", flag,
                    (len >= N) && (k >= N + 2) && (k < len + N + 2));
            end
            idle(3);
        end

        // R4: train of sub-threshold pulses with one-cycle gaps
        for (int p = 0; p < 5; p++) begin
            ilim = 1'b1;
            for (int k = 0; k < N - 1; k++) begin
                @(negedge clk);
                chk("R4", "flag in pulse train", flag, 1'b0);
            end
            ilim = 1'b0;
            @(negedge clk);
            chk("R4", "flag in pulse train", flag, 1'b0);
        end
        for (int k = 0; k < N + 4; k++) begin
            @(negedge clk);
            chk("R4", "flag after pulse train", flag, 1'b0);
        end

        // R5: a one-cycle return during release restarts the release count
        ilim = 1'b1;
        idle(N + 2);
        chk("R5", "flag set before release", flag, 1'b1);
        ilim = 1'b0;
        for (int k = 1; k <= 2 * N + 4; k++) begin
            @(negedge clk);
            if (k == N - 1) ilim = 1'b1;
            if (k == N) ilim = 1'b0;
            chk("R5", "flag during restarted release", flag, k < 2 * N + 2);
        end
        idle(4);

        // R6 R9: overtemperature during current limit
        ilim = 1'b1;
        idle(3);
        chk("R6", "flag before overtemp", flag, 1'b0);
        ot = 1'b1;
        for (int k = 1; k <= 3; k++) begin
            @(negedge clk);
            chk("R6", "flag on overtemp", flag, k >= 3);
            chk("R9", "switch on overtemp", sw, k < 3);
        end
        ilim = 1'b0; ot = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            chk("R9", "switch held off while hot", sw, 1'b0);
            chk("R6", "flag held while hot", flag, 1'b1);
        end
        cool = 1'b1;
        for (int k = 1; k <= N + 5; k++) begin
            @(negedge clk);
            chk("R9", "switch after cooled", sw, k >= 3);
            chk("R6", "flag release after cooled", flag, k < N + 3);
        end
        cool = 1'b0;
        idle(4);

        // R7: disable in mid-fault, then re-enable into the overload
        ilim = 1'b1;
        idle(N + 2);
        chk("R7", "flag set before disable", flag, 1'b1);
        en = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R7", "flag on disable", flag, k < 2);
            chk("R7", "switch on disable", sw, k < 2);
        end
        en = 1'b1;
        for (int k = 1; k <= N + 4; k++) begin
            @(negedge clk);
            chk("R7", "flag after re-enable", flag, k >= N + 2);
            chk("R10", "switch after re-enable", sw, k >= 2);
        end
        ilim = 1'b0;
        idle(N + 6);

        // R8: supply loss with overload and overtemperature present
        ok = 1'b0; ilim = 1'b1; ot = 1'b1;
        for (int k = 1; k <= 2 * N + 6; k++) begin
            @(negedge clk);
            chk("R8", "flag in lockout", flag, 1'b0);
            chk("R8", "switch in lockout", sw, k < 2);
        end
        ilim = 1'b0; ot = 1'b0;
        idle(3);
        ok = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            chk("R8", "switch after lockout, no latched shutdown", sw, k >= 2);
            chk("R8", "flag after lockout", flag, 1'b0);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule